// File: doc/BRIEF.md
# Power-On Row Fault Scanner

This block sits between a word-oriented two-port memory (one write port, one read port) and the logic that normally uses it. On leaving reset it takes both memory ports for itself and sweeps every row: it writes a known word, reads the same row back on the next cycle, and compares the word read against the word written one cycle earlier. If any bit of the word differs, that row is condemned. The flag is set only for the row whose read select was active, and it stays set. Rows are condemned one by one as they are read, so the block keeps no list of faulty addresses.

The sweep makes two passes over the array. The first writes all-zeros words and the second writes all-ones words, so a bit stuck at either value is caught. When the second pass ends, the block drops its test-mode output, pulses a done strobe for one cycle and gives the memory ports back to the system inputs. The per-row flag vector and a count of flagged rows stay readable until the next reset. Repair logic can use them to steer accesses away from the condemned rows.

Top module: `row_fault_scan`

## Requirements
- R1: While reset is asserted, all row flags are 0, the flagged-row count is 0, the test-mode output is 1 and the done strobe is 0.
- R2: After reset is released, the test-mode output stays 1 for exactly 4*ROWS cycles and then stays 0. The done strobe is 1 only in the first cycle in which the test-mode output is 0.
- R3: The test sweep has two passes, in the order zeros then ones, and each pass covers rows 0 to ROWS-1 in ascending order. In cycle 2i of a pass, row i is written (write enable 1, read enable 0). In cycle 2i+1, row i is read (read enable 1, write enable 0). The first pass writes every bit 0 and the second pass writes every bit 1.
- R4: While the test-mode output is 1, the system-side write and read inputs have no effect on the memory ports.
- R5: While the test-mode output is 0, every memory port output equals the matching system-side input in the same cycle.
- R6: In a test read cycle, the read data is compared bit by bit with the word written one cycle earlier. A difference in any single bit sets the flag of the row being read, and no other flag changes.
- R7: A bit stuck at 1 is flagged by the end of the zeros pass. A bit stuck at 0 in a row with no stuck-at-1 bit is flagged only during the ones pass.
- R8: Row flags never return from 1 to 0 without a reset, and no flag changes while the test-mode output is 0, whatever data the memory returns.
- R9: The flagged-row count output always equals the number of row flags that are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sys_wr_en | input | 1 | System write enable |
| sys_wr_addr | input | AW | System write row address |
| sys_wr_data | input | DW | System write word |
| sys_rd_en | input | 1 | System read enable |
| sys_rd_addr | input | AW | System read row address |
| mem_rd_data | input | DW | Word returned by the memory for mem_rd_addr, in the same cycle |
| mem_wr_en | output | 1 | Write enable to the memory |
| mem_wr_addr | output | AW | Write row address to the memory |
| mem_wr_data | output | DW | Write word to the memory |
| mem_rd_en | output | 1 | Read enable to the memory |
| mem_rd_addr | output | AW | Read row address to the memory |
| test_active | output | 1 | 1 while the sweep owns the memory ports |
| scan_done | output | 1 | One-cycle strobe when the sweep hands the ports back |
| fault_flags | output | ROWS | One sticky flag per row, bit i for row i |
| fail_count | output | CW | Number of flagged rows |

## Verification
The memory model in the bench holds random initial contents and can force chosen bits of chosen rows to a fixed value. The bench runs the sweep against a fault-free array and against an array in which every row has one stuck bit. It also runs a case with a stuck-at-1 MSB in row 0 and a stuck-at-0 LSB in the last row, which shows that the flags follow the pass order and land on the array boundaries. Several seeded random fault maps mix both polarities. After each sweep the bench drives random system traffic. This shows that the system inputs are ignored during the test, that they pass straight through afterwards, and that reads returning mismatching data in normal mode leave the flags untouched.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    SEQ_WRITE = 2'd0,
    SEQ_READ  = 2'd1,
    SEQ_IDLE  = 2'd2
  } seq_state_e;

  // Number of test cycles for a given row count: two passes, write+read per row.
  function automatic int unsigned sweep_cycles(input int unsigned rows);
    return 4 * rows;
  endfunction

endpackage

// File: rtl/rfs_sweep_seq.sv
module rfs_sweep_seq import rfs_pkg::*; #(
  parameter int ROWS = 16,
  parameter int AW   = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          seq_wr,
  output logic          seq_rd,
  output logic [AW-1:0] seq_addr,
  output logic          seq_pass,
  output logic          test_active,
  output logic          scan_done
);

  localparam logic [AW-1:0] LAST_ROW = AW'(ROWS - 1);

  seq_state_e   state_q;
  logic [AW-1:0] addr_q;
  logic          pass_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_WRITE;
      addr_q  <= '0;
      pass_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_WRITE: state_q <= SEQ_READ;
        SEQ_READ: begin
          if (addr_q == LAST_ROW) begin
            addr_q <= '0;
            if (pass_q) begin
              state_q <= SEQ_IDLE;
              done_q  <= 1'b1;
            end else begin
              pass_q  <= 1'b1;
              state_q <= SEQ_WRITE;
            end
          end else begin
            addr_q  <= addr_q + 1'b1;
            state_q <= SEQ_WRITE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign seq_wr      = (state_q == SEQ_WRITE);
  assign seq_rd      = (state_q == SEQ_READ);
  assign seq_addr    = addr_q;
  assign seq_pass    = pass_q;
  assign test_active = (state_q != SEQ_IDLE);
  assign scan_done   = done_q;

endmodule

// File: rtl/rfs_port_sel.sv
module rfs_port_sel #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          test_active,
  input  logic          seq_wr,
  input  logic          seq_rd,
  input  logic [AW-1:0] seq_addr,
  input  logic [DW-1:0] seq_data,
  input  logic          sys_wr_en,
  input  logic [AW-1:0] sys_wr_addr,
  input  logic [DW-1:0] sys_wr_data,
  input  logic          sys_rd_en,
  input  logic [AW-1:0] sys_rd_addr,
  output logic          mem_wr_en,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  output logic          mem_rd_en,
  output logic [AW-1:0] mem_rd_addr
);

  always_comb begin
    if (test_active) begin
      mem_wr_en   = seq_wr;
      mem_wr_addr = seq_addr;
      mem_wr_data = seq_data;
      mem_rd_en   = seq_rd;
      mem_rd_addr = seq_addr;
    end else begin
      mem_wr_en   = sys_wr_en;
      mem_wr_addr = sys_wr_addr;
      mem_wr_data = sys_wr_data;
      mem_rd_en   = sys_rd_en;
      mem_rd_addr = sys_rd_addr;
    end
  end

endmodule

// File: rtl/rfs_row_check.sv
module rfs_row_check #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_wr,
  input  logic [DW-1:0] chk_wdata,
  input  logic          chk_rd,
  input  logic [DW-1:0] chk_rdata,
  output logic          fault_pulse
);

  logic [DW-1:0] wdata_d;
  logic          wr_d;

  function automatic logic any_bit_differs(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < DW; i++) hit = hit | (a[i] ^ b[i]);
    return hit;
  endfunction

  // The written word is held one cycle to meet the read of the same row.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_d <= '0;
      wr_d    <= 1'b0;
    end else begin
      wdata_d <= chk_wdata;
      wr_d    <= chk_wr;
    end
  end

  assign fault_pulse = chk_rd && wr_d && any_bit_differs(wdata_d, chk_rdata);

endmodule

// File: rtl/rfs_flag_bank.sv
module rfs_flag_bank #(
  parameter int ROWS = 16,
  parameter int AW   = $clog2(ROWS),
  parameter int CW   = $clog2(ROWS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fault_pulse,
  input  logic            rd_sel_en,
  input  logic [AW-1:0]   rd_sel_addr,
  output logic [ROWS-1:0] flags,
  output logic [CW-1:0]   count
);

  logic [ROWS-1:0] row_hit;

  function automatic logic [CW-1:0] count_set(input logic [ROWS-1:0] v);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < ROWS; i++) n = n + CW'(v[i]);
    return n;
  endfunction

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign row_hit[g] = fault_pulse && rd_sel_en && (rd_sel_addr == AW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[g] <= 1'b0;
      else if (row_hit[g]) flags[g] <= 1'b1;
    end
  end

  assign count = count_set(flags);

endmodule

// File: rtl/row_fault_scan.sv
module row_fault_scan #(
  parameter  int ROWS = 16,
  parameter  int DW   = 8,
  localparam int AW   = $clog2(ROWS),
  localparam int CW   = $clog2(ROWS + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sys_wr_en,
  input  logic [AW-1:0]   sys_wr_addr,
  input  logic [DW-1:0]   sys_wr_data,
  input  logic            sys_rd_en,
  input  logic [AW-1:0]   sys_rd_addr,
  input  logic [DW-1:0]   mem_rd_data,
  output logic            mem_wr_en,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [DW-1:0]   mem_wr_data,
  output logic            mem_rd_en,
  output logic [AW-1:0]   mem_rd_addr,
  output logic            test_active,
  output logic            scan_done,
  output logic [ROWS-1:0] fault_flags,
  output logic [CW-1:0]   fail_count
);

  logic          seq_wr;
  logic          seq_rd;
  logic [AW-1:0] seq_addr;
  logic          seq_pass;
  logic [DW-1:0] seq_data;
  logic          fault_pulse;

  assign seq_data = {DW{seq_pass}};

  rfs_sweep_seq #(.ROWS(ROWS), .AW(AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_wr      (seq_wr),
    .seq_rd      (seq_rd),
    .seq_addr    (seq_addr),
    .seq_pass    (seq_pass),
    .test_active (test_active),
    .scan_done   (scan_done)
  );

  rfs_port_sel #(.AW(AW), .DW(DW)) u_sel (
    .test_active (test_active),
    .seq_wr      (seq_wr),
    .seq_rd      (seq_rd),
    .seq_addr    (seq_addr),
    .seq_data    (seq_data),
    .sys_wr_en   (sys_wr_en),
    .sys_wr_addr (sys_wr_addr),
    .sys_wr_data (sys_wr_data),
    .sys_rd_en   (sys_rd_en),
    .sys_rd_addr (sys_rd_addr),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr)
  );

  rfs_row_check #(.DW(DW)) u_chk_row (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_wr      (seq_wr),
    .chk_wdata   (seq_data),
    .chk_rd      (seq_rd),
    .chk_rdata   (mem_rd_data),
    .fault_pulse (fault_pulse)
  );

  rfs_flag_bank #(.ROWS(ROWS), .AW(AW), .CW(CW)) u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault_pulse (fault_pulse),
    .rd_sel_en   (seq_rd),
    .rd_sel_addr (seq_addr),
    .flags       (fault_flags),
    .count       (fail_count)
  );

endmodule

// File: rtl/row_fault_scan_chk.sv
module row_fault_scan_chk #(
  parameter  int ROWS = 16,
  parameter  int DW   = 8,
  localparam int AW   = $clog2(ROWS)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            test_active,
  input logic            scan_done,
  input logic            mem_wr_en,
  input logic [AW-1:0]   mem_wr_addr,
  input logic            mem_rd_en,
  input logic [AW-1:0]   mem_rd_addr,
  input logic            sys_wr_en,
  input logic [AW-1:0]   sys_wr_addr,
  input logic            sys_rd_en,
  input logic [AW-1:0]   sys_rd_addr,
  input logic [ROWS-1:0] fault_flags,
  input logic            fault_pulse
);

  // R2: the strobe only appears with the ports released, and lasts one cycle
  p_done_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !test_active);
  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);
  p_fall_marks_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(test_active) |-> scan_done);
  p_no_reentry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !test_active |=> !test_active);

  // R3: every test write is followed by the read of the same row
  p_write_then_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_active && mem_wr_en) |=> (mem_rd_en && !mem_wr_en && mem_rd_addr == $past(mem_wr_addr)));

  // R5: normal mode hands the ports to the system side
  p_pass_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !test_active |-> (mem_wr_en == sys_wr_en && mem_wr_addr == sys_wr_addr &&
                      mem_rd_en == sys_rd_en && mem_rd_addr == sys_rd_addr));

  // R6: a mismatch sets the flag of the row read, and nothing else moves
  p_hit_sets_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> fault_flags[$past(mem_rd_addr)]);
  p_only_read_row_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> ((fault_flags ^ $past(fault_flags)) & ~(ROWS'(1) << $past(mem_rd_addr))) == '0);
  p_quiet_without_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_pulse |=> $stable(fault_flags));

  // R8: flags are sticky and frozen in normal mode
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((fault_flags & $past(fault_flags)) == $past(fault_flags)));
  p_frozen_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !test_active |=> $stable(fault_flags));

endmodule

bind row_fault_scan row_fault_scan_chk #(.ROWS(ROWS), .DW(DW)) u_scan_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .test_active (test_active),
  .scan_done   (scan_done),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_addr (mem_wr_addr),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr),
  .sys_wr_en   (sys_wr_en),
  .sys_wr_addr (sys_wr_addr),
  .sys_rd_en   (sys_rd_en),
  .sys_rd_addr (sys_rd_addr),
  .fault_flags (fault_flags),
  .fault_pulse (fault_pulse)
);

// File: tb/test_row_fault_scan.sv
`timescale 1ns/1ps
module test_row_fault_scan;

  localparam int ROWS = 16;
  localparam int DW   = 8;
  localparam int AW   = $clog2(ROWS);
  localparam int CW   = $clog2(ROWS + 1);
  localparam int TCYC = 4 * ROWS;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            sys_wr_en = 1'b0;
  logic [AW-1:0]   sys_wr_addr = '0;
  logic [DW-1:0]   sys_wr_data = '0;
  logic            sys_rd_en = 1'b0;
  logic [AW-1:0]   sys_rd_addr = '0;
  logic [DW-1:0]   mem_rd_data;
  logic            mem_wr_en;
  logic [AW-1:0]   mem_wr_addr;
  logic [DW-1:0]   mem_wr_data;
  logic            mem_rd_en;
  logic [AW-1:0]   mem_rd_addr;
  logic            test_active;
  logic            scan_done;
  logic [ROWS-1:0] fault_flags;
  logic [CW-1:0]   fail_count;

  always #2 clk = ~clk;

  row_fault_scan #(.ROWS(ROWS), .DW(DW)) i_row_fault_scan (.*);

  // Behavioural memory: combinational read, forced bits on the read path
  logic [DW-1:0] mem        [ROWS];
  logic [DW-1:0] stuck_mask [ROWS];
  logic [DW-1:0] stuck_val  [ROWS];

  always @(posedge clk) if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
  assign mem_rd_data = (mem[mem_rd_addr] & ~stuck_mask[mem_rd_addr]) |
                       (stuck_val[mem_rd_addr] & stuck_mask[mem_rd_addr]);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ROWS-1:0] rows_with(input bit polarity);
    logic [ROWS-1:0] r;
    for (int i = 0; i < ROWS; i++)
      r[i] = polarity ? |(stuck_mask[i] & stuck_val[i]) : |(stuck_mask[i] & ~stuck_val[i]);
    return r;
  endfunction

  function automatic int ones_of(input logic [ROWS-1:0] v);
    int n = 0;
    for (int i = 0; i < ROWS; i++) n += v[i];
    return n;
  endfunction

  task automatic drive_sys_random();
    sys_wr_en   = 1'($urandom);
    sys_wr_addr = AW'($urandom);
    sys_wr_data = DW'($urandom);
    sys_rd_en   = 1'($urandom);
    sys_rd_addr = AW'($urandom);
  endtask

  task automatic run_scan();
    logic [ROWS-1:0] exp1, exp0, exp_all, held;
    rst_n = 1'b0;
    for (int i = 0; i < ROWS; i++) mem[i] = DW'($urandom);
    drive_sys_random();
    repeat (3) @(negedge clk);
    #1;
    chk(fault_flags == '0, "R1", "flags in reset", fault_flags, 0);
    chk(fail_count == '0, "R1", "count in reset", fail_count, 0);
    chk(test_active == 1'b1, "R1", "test_active in reset", test_active, 1);
    chk(scan_done == 1'b0, "R1", "done in reset", scan_done, 0);
    exp1 = rows_with(1'b1);
    exp0 = rows_with(1'b0);
    exp_all = exp1 | exp0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k <= TCYC + 1; k++) begin
      drive_sys_random();   // R4: must not reach the memory during the sweep
      #1;
      chk(test_active == (k < TCYC), "R2", "test_active window", test_active, k < TCYC);
      chk(scan_done == (k == TCYC), "R2", "done strobe", scan_done, k == TCYC);
      if (k < TCYC) begin
        chk(mem_wr_en == (k % 2 == 0), "R3", "write slot", mem_wr_en, k % 2 == 0);
        chk(mem_rd_en == (k % 2 == 1), "R4", "read slot", mem_rd_en, k % 2 == 1);
        if (k % 2 == 0) begin
          chk(mem_wr_addr == AW'((k / 2) % ROWS), "R4", "sweep write row", mem_wr_addr, (k / 2) % ROWS);
          chk(mem_wr_data == ((k >= 2 * ROWS) ? {DW{1'b1}} : {DW{1'b0}}), "R3", "pass pattern",
              mem_wr_data, (k >= 2 * ROWS) ? {DW{1'b1}} : {DW{1'b0}});
        end else begin
          chk(mem_rd_addr == AW'((k / 2) % ROWS), "R3", "sweep read row", mem_rd_addr, (k / 2) % ROWS);
        end
      end
      if (k == 2 * ROWS)
        chk(fault_flags == exp1, "R7", "flags after zeros pass", fault_flags, exp1);
      @(negedge clk);
    end
    #1;
    chk(fault_flags == exp_all, "R6", "final flags", fault_flags, exp_all);
    chk(int'(fail_count) == ones_of(exp_all), "R9", "flag count", fail_count, ones_of(exp_all));
    held = fault_flags;
    for (int k = 0; k < 24; k++) begin
      drive_sys_random();
      if (k == 0) begin
        sys_rd_en = 1'b1;   // read a row whose data cannot match anything written
        sys_wr_en = 1'b0;
      end
      #1;
      chk(mem_wr_en == sys_wr_en && mem_wr_addr == sys_wr_addr && mem_wr_data == sys_wr_data,
          "R5", "write pass-through", {mem_wr_en, mem_wr_addr, mem_wr_data}, {sys_wr_en, sys_wr_addr, sys_wr_data});
      chk(mem_rd_en == sys_rd_en && mem_rd_addr == sys_rd_addr, "R5", "read pass-through",
          {mem_rd_en, mem_rd_addr}, {sys_rd_en, sys_rd_addr});
      chk(test_active == 1'b0 && scan_done == 1'b0, "R2", "stays released",
          {test_active, scan_done}, 0);
      @(negedge clk);
      #1;
      chk(fault_flags == held, "R8", "flags frozen in normal mode", fault_flags, held);
      chk(int'(fail_count) == ones_of(held), "R9", "count frozen", fail_count, ones_of(held));
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i < ROWS; i++) begin
      stuck_mask[i] = '0;
      stuck_val[i]  = '0;
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    clear_faults();
    for (int i = 0; i < ROWS; i++) mem[i] = '0;

    // No faults: nothing may be flagged (R6, R9)
    run_scan();

    // Every row has one stuck bit of random polarity (R6, R7)
    for (int i = 0; i < ROWS; i++) begin
      stuck_mask[i] = DW'(1) << ($urandom % DW);
      stuck_val[i]  = DW'($urandom);
    end
    run_scan();

    // Boundary rows: MSB stuck at 1 in row 0, LSB stuck at 0 in the last row (R7)
    clear_faults();
    stuck_mask[0] = DW'(1) << (DW - 1);
    stuck_val[0]  = '1;
    stuck_mask[ROWS-1] = DW'(1);
    stuck_val[ROWS-1]  = '0;
    run_scan();

    // Seeded random fault maps
    for (int r = 0; r < 5; r++) begin
      clear_faults();
      for (int i = 0; i < ROWS; i++) begin
        if ($urandom % 3 == 0) begin
          stuck_mask[i] = DW'($urandom) | DW'(1) << ($urandom % DW);
          stuck_val[i]  = DW'($urandom);
        end
      end
      run_scan();
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule